// File: doc/BRIEF.md
# DDR2 Bank Command Timing Monitor

This block watches a DDR2-style command bus without driving it. On every rising clock edge it decodes the chip-select, row strobe, column strobe and write-enable lines, together with the bank-select bits and address bit 10. It keeps an open or closed state and two cycle counters for each bank. It also keeps shared counters for the most recent activate to any bank and for the most recent read. Whenever a command breaks one of the spacing rules, the block reports it on a registered violation pulse. The pulse carries a 3-bit rule code and the index of the bank at fault.

The minimum cycle counts are static configuration inputs: row cycle, activate-to-activate across banks, activate-to-read, active time and precharge time. The read-to-read spacing and the additive latency (0 to 6) are configured the same way. The activate-to-read rule is checked at the internally posted read time, which is the issue cycle plus the additive latency. The rule is not checked at the cycle the read appears on the bus. Each decoded command updates the tracked state whether or not it was flagged, so the monitor always mirrors what the device was told. `rst_n` is asynchronous when asserted and must be released in step with `clk`.

Top module: `ddr_bank_timing_mon`

## Requirements
- R1: After reset every bank is closed and every counter is saturated. No violation is reported, and a first activate to any bank is legal.
- R2: The decoder classifies each cycle by the strobes {ras_n, cas_n, we_n}, provided cs_n is low. 011 is an activate, 101 is a read, 100 is a write and 010 is a precharge. Every other pattern, and any cycle with cs_n high, is ignored and changes no state.
- R3: A read or write to a closed bank raises code 0 for that bank.
- R4: An activate to a bank that is already open raises code 1.
- R5: An activate less than cfg_trc cycles after the previous activate to the same bank raises code 2.
- R6: An activate less than cfg_trrd cycles after the previous activate to any bank raises code 3.
- R7: A read to an open bank raises code 4 when (cycles since that bank's activate) + cfg_al is less than cfg_trcd.
- R8: A read less than cfg_tccd cycles after the previous read raises code 5.
- R9: A precharge to an open bank less than cfg_tras cycles after its activate raises code 6. A precharge with a10 high closes every open bank, and the lowest-indexed offending bank is reported.
- R10: An activate less than cfg_trp cycles after that bank was closed raises code 7.
- R11: A read or write with a10 high closes its open bank, and the precharge timer starts at that command. Later accesses need a new activate.
- R12: The violation fields are registered and valid for exactly one cycle, in the cycle after the command. When more than one rule applies, the order is: for an activate 1, 2, 7, 3; for a read 0, 4, 5. Code and bank read zero when no violation is flagged.
- R13: A single-bank precharge (a10 low) to a closed bank is not a violation and leaves the timers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select |
| a10 | input | 1 | Address bit 10: auto-precharge or precharge-all |
| cfg_trc | input | CNT_W (6) | Same-bank activate spacing, cycles |
| cfg_trrd | input | CNT_W (6) | Any-bank activate spacing, cycles |
| cfg_trcd | input | CNT_W (6) | Activate to internal read, cycles |
| cfg_tras | input | CNT_W (6) | Minimum active time, cycles |
| cfg_trp | input | CNT_W (6) | Precharge to activate, cycles |
| cfg_tccd | input | CNT_W (6) | Read to read, cycles |
| cfg_al | input | 3 | Additive latency, 0 to 6 |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Rule code of the violation |
| viol_bank_o | output | BA_W (2) | Bank at fault |

## Verification
The properties assume that reset is held with cs_n high, so that no command is pending when tracking starts. They also assume the configuration inputs stay fixed between resets and that cfg_al never exceeds 6. The bench changes the configuration only while reset is held. It issues at most one command per cycle from a fixed small timing set, and it returns the bus to no-operation between commands, so every expected code follows from cycle distances it counts itself.

// File: rtl/dbtm_pkg.sv
package dbtm_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    VIO_CLOSED   = 3'd0,
    VIO_ACT_OPEN = 3'd1,
    VIO_RC       = 3'd2,
    VIO_RRD      = 3'd3,
    VIO_RCD      = 3'd4,
    VIO_CCD      = 3'd5,
    VIO_RAS      = 3'd6,
    VIO_RP       = 3'd7
  } vio_e;

endpackage

// File: rtl/dbtm_decode.sv
module dbtm_decode
  import dbtm_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/dbtm_satcnt.sv
module dbtm_satcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] SAT = {W{1'b1}};

  logic         en;
  logic [W-1:0] q_nxt;

  always_comb begin
    en    = restart || (q != SAT);
    q_nxt = restart ? W'(1) : q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= SAT;
    end else if (en) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/dbtm_bank.sv
module dbtm_bank #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             close_i,
  output logic             open_o,
  output logic [CNT_W-1:0] since_act_o,
  output logic [CNT_W-1:0] since_pre_o
);

  logic open_en;
  logic open_nxt;

  always_comb begin
    open_en  = act_i || close_i;
    open_nxt = act_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
    end else if (open_en) begin
      open_o <= open_nxt;
    end
  end

  dbtm_satcnt #(.W(CNT_W)) u_act_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (act_i),
    .q       (since_act_o)
  );

  dbtm_satcnt #(.W(CNT_W)) u_pre_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (close_i),
    .q       (since_pre_o)
  );

endmodule

// File: rtl/dbtm_rules.sv
module dbtm_rules
  import dbtm_pkg::*;
#(
  parameter int NB    = 4,
  parameter int CNT_W = 6,
  parameter int AL_W  = 3,
  localparam int BA_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  cmd_e                      cmd,
  input  logic [BA_W-1:0]           ba,
  input  logic                      a10,
  input  logic [NB-1:0]             bank_open,
  input  logic [NB-1:0][CNT_W-1:0]  since_act,
  input  logic [NB-1:0][CNT_W-1:0]  since_pre,
  input  logic [CNT_W-1:0]          since_any_act,
  input  logic [CNT_W-1:0]          since_rd,
  input  logic [CNT_W-1:0]          cfg_trc,
  input  logic [CNT_W-1:0]          cfg_trrd,
  input  logic [CNT_W-1:0]          cfg_trcd,
  input  logic [CNT_W-1:0]          cfg_tras,
  input  logic [CNT_W-1:0]          cfg_trp,
  input  logic [CNT_W-1:0]          cfg_tccd,
  input  logic [AL_W-1:0]           cfg_al,
  output logic                      hit,
  output vio_e                      code,
  output logic [BA_W-1:0]           hit_bank,
  output logic [NB-1:0]             act_vec,
  output logic [NB-1:0]             close_vec,
  output logic                      any_act,
  output logic                      any_rd
);

  localparam int SUM_W = CNT_W + 1;

  logic [NB-1:0]    sel;
  logic [SUM_W-1:0] posted;

  always_comb begin
    sel    = NB'(1) << ba;
    posted = {1'b0, since_act[ba]} + SUM_W'(cfg_al);
  end

  // Event steering into the trackers
  always_comb begin
    act_vec   = '0;
    close_vec = '0;
    any_act   = 1'b0;
    any_rd    = 1'b0;
    case (cmd)
      CMD_ACT: begin
        act_vec = sel;
        any_act = 1'b1;
      end
      CMD_RD: begin
        any_rd = 1'b1;
        if (a10) close_vec = sel & bank_open;
      end
      CMD_WR: begin
        if (a10) close_vec = sel & bank_open;
      end
      CMD_PRE: begin
        close_vec = a10 ? bank_open : (sel & bank_open);
      end
      default: ;
    endcase
  end

  // Rule evaluation, priority order inside each command
  always_comb begin
    hit      = 1'b0;
    code     = VIO_CLOSED;
    hit_bank = ba;
    case (cmd)
      CMD_ACT: begin
        if (bank_open[ba]) begin
          hit = 1'b1; code = VIO_ACT_OPEN;
        end else if (since_act[ba] < cfg_trc) begin
          hit = 1'b1; code = VIO_RC;
        end else if (since_pre[ba] < cfg_trp) begin
          hit = 1'b1; code = VIO_RP;
        end else if (since_any_act < cfg_trrd) begin
          hit = 1'b1; code = VIO_RRD;
        end
      end
      CMD_RD: begin
        if (!bank_open[ba]) begin
          hit = 1'b1; code = VIO_CLOSED;
        end else if (posted < {1'b0, cfg_trcd}) begin
          hit = 1'b1; code = VIO_RCD;
        end else if (since_rd < cfg_tccd) begin
          hit = 1'b1; code = VIO_CCD;
        end
      end
      CMD_WR: begin
        if (!bank_open[ba]) begin
          hit = 1'b1; code = VIO_CLOSED;
        end
      end
      CMD_PRE: begin
        if (a10) begin
          for (int i = 0; i < NB; i++) begin
            if (!hit && bank_open[i] && (since_act[i] < cfg_tras)) begin
              hit      = 1'b1;
              code     = VIO_RAS;
              hit_bank = BA_W'(i);
            end
          end
        end else if (bank_open[ba] && (since_act[ba] < cfg_tras)) begin
          hit = 1'b1; code = VIO_RAS;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_bank_timing_mon.sv
module ddr_bank_timing_mon
  import dbtm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6,
  parameter int AL_W      = 3,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  input  logic [CNT_W-1:0] cfg_trc,
  input  logic [CNT_W-1:0] cfg_trrd,
  input  logic [CNT_W-1:0] cfg_trcd,
  input  logic [CNT_W-1:0] cfg_tras,
  input  logic [CNT_W-1:0] cfg_trp,
  input  logic [CNT_W-1:0] cfg_tccd,
  input  logic [AL_W-1:0]  cfg_al,
  output logic             viol_o,
  output logic [2:0]       viol_code_o,
  output logic [BA_W-1:0]  viol_bank_o
);

  cmd_e                           cmd;
  logic [NUM_BANKS-1:0]           bank_open;
  logic [NUM_BANKS-1:0][CNT_W-1:0] since_act;
  logic [NUM_BANKS-1:0][CNT_W-1:0] since_pre;
  logic [CNT_W-1:0]               since_any_act;
  logic [CNT_W-1:0]               since_rd;
  logic [NUM_BANKS-1:0]           act_vec;
  logic [NUM_BANKS-1:0]           close_vec;
  logic                           any_act;
  logic                           any_rd;
  logic                           hit;
  vio_e                           code;
  logic [BA_W-1:0]                hit_bank;

  logic                           viol_nxt;
  logic [2:0]                     code_nxt;
  logic [BA_W-1:0]                bank_nxt;

  dbtm_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbtm_bank #(.CNT_W(CNT_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_i       (act_vec[b]),
      .close_i     (close_vec[b]),
      .open_o      (bank_open[b]),
      .since_act_o (since_act[b]),
      .since_pre_o (since_pre[b])
    );
  end

  dbtm_satcnt #(.W(CNT_W)) u_any_act_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (any_act),
    .q       (since_any_act)
  );

  dbtm_satcnt #(.W(CNT_W)) u_rd_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (any_rd),
    .q       (since_rd)
  );

  dbtm_rules #(.NB(NUM_BANKS), .CNT_W(CNT_W), .AL_W(AL_W)) u_rules (
    .cmd           (cmd),
    .ba            (ba),
    .a10           (a10),
    .bank_open     (bank_open),
    .since_act     (since_act),
    .since_pre     (since_pre),
    .since_any_act (since_any_act),
    .since_rd      (since_rd),
    .cfg_trc       (cfg_trc),
    .cfg_trrd      (cfg_trrd),
    .cfg_trcd      (cfg_trcd),
    .cfg_tras      (cfg_tras),
    .cfg_trp       (cfg_trp),
    .cfg_tccd      (cfg_tccd),
    .cfg_al        (cfg_al),
    .hit           (hit),
    .code          (code),
    .hit_bank      (hit_bank),
    .act_vec       (act_vec),
    .close_vec     (close_vec),
    .any_act       (any_act),
    .any_rd        (any_rd)
  );

  always_comb begin
    viol_nxt = hit;
    code_nxt = hit ? 3'(code) : 3'd0;
    bank_nxt = hit ? hit_bank : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_o      <= 1'b0;
      viol_code_o <= 3'd0;
      viol_bank_o <= '0;
    end else begin
      viol_o      <= viol_nxt;
      viol_code_o <= code_nxt;
      viol_bank_o <= bank_nxt;
    end
  end

endmodule

// File: rtl/dbtm_checker.sv
module dbtm_checker #(
  parameter int NB   = 4,
  localparam int BA_W = (NB > 1) ? $clog2(NB) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic            a10,
  input logic [NB-1:0]   bank_open,
  input logic            viol_o,
  input logic [2:0]      viol_code_o,
  input logic [BA_W-1:0] viol_bank_o
);

  logic is_act, is_rd, is_wr, is_pre;
  assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
  assign is_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;
  assign is_wr  = !cs_n &&  ras_n && !cas_n && !we_n;
  assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;

  // R2: a deselected cycle never produces a report
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !viol_o);

  // R3: access to a closed bank
  a_r3_closed_access: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_rd || is_wr) && !bank_open[ba]) |=>
      (viol_o && viol_code_o == 3'd0 && viol_bank_o == $past(ba)));

  // R4: activate to an open bank
  a_r4_act_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && bank_open[ba]) |=> (viol_o && viol_code_o == 3'd1));

  // R11: auto-precharge closes the bank
  a_r11_autopre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_rd || is_wr) && a10) |=> !bank_open[$past(ba)]);

  // R12: idle outputs read zero
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_o |-> (viol_code_o == 3'd0 && viol_bank_o == '0));

  // R13: precharge of an idle bank is harmless
  a_r13_pre_idle_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && !a10 && !bank_open[ba]) |=> !viol_o);

  // R9: precharge-all leaves every bank closed
  a_r9_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10) |=> (bank_open == '0));

endmodule

bind ddr_bank_timing_mon dbtm_checker #(.NB(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .ba          (ba),
  .a10         (a10),
  .bank_open   (bank_open),
  .viol_o      (viol_o),
  .viol_code_o (viol_code_o),
  .viol_bank_o (viol_bank_o)
);

// File: tb/ddr_bank_timing_mon_test.sv
module ddr_bank_timing_mon_test;

  localparam int T_RC = 6, T_RRD = 2, T_RCD = 3, T_RAS = 4, T_RP = 3, T_CCD = 2;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_DES = 5, C_REF = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [5:0] cfg_trc, cfg_trrd, cfg_trcd, cfg_tras, cfg_trp, cfg_tccd;
  logic [2:0] cfg_al;
  logic       viol_o;
  logic [2:0] viol_code_o;
  logic [1:0] viol_bank_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ddr_bank_timing_mon uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .cfg_trc(cfg_trc), .cfg_trrd(cfg_trrd), .cfg_trcd(cfg_trcd),
    .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_tccd(cfg_tccd), .cfg_al(cfg_al),
    .viol_o(viol_o), .viol_code_o(viol_code_o), .viol_bank_o(viol_bank_o)
  );

  task automatic drive(input int c, input int b, input bit x10);
    ba  = 2'(b);
    a10 = x10;
    cs_n = 1'b0;
    case (c)
      C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      C_RD:    {ras_n, cas_n, we_n} = 3'b101;
      C_WR:    {ras_n, cas_n, we_n} = 3'b100;
      C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      C_REF:   {ras_n, cas_n, we_n} = 3'b001;
      C_DES:   begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; end
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
  endtask

  // exp_code < 0 means no violation expected
  task automatic check(input int exp_code, input int exp_bank, input string tag);
    bit ok;
    checks++;
    if (exp_code < 0) ok = (viol_o == 1'b0) && (viol_code_o == 3'd0) && (viol_bank_o == 2'd0);
    else ok = viol_o && (viol_code_o == 3'(exp_code)) && (viol_bank_o == 2'(exp_bank));
    if (!ok) begin
      errors++;
      $display("FAIL %s: got v=%0d code=%0d bank=%0d, expected code=%0d bank=%0d",
               tag, viol_o, viol_code_o, viol_bank_o, exp_code, exp_bank);
    end
  endtask

  task automatic step(input int c, input int b, input bit x10,
                      input int exp_code, input int exp_bank, input string tag);
    drive(c, b, x10);
    @(negedge clk);
    check(exp_code, exp_bank, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(C_NOP, 0, 1'b0, -1, 0, "R12 idle pulse ends");
  endtask

  task automatic do_reset(input int al);
    drive(C_DES, 0, 1'b0);
    rst_n  = 1'b0;
    cfg_al = 3'(al);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    cfg_trc = 6'(T_RC); cfg_trrd = 6'(T_RRD); cfg_trcd = 6'(T_RCD);
    cfg_tras = 6'(T_RAS); cfg_trp = 6'(T_RP); cfg_tccd = 6'(T_CCD);
    do_reset(0);

    // R1: reset state, then closed-bank access and a free activate
    check(-1, 0, "R1 reset outputs");
    step(C_RD, 1, 1'b0, 0, 1, "R1 R3 read closed bank");
    step(C_WR, 2, 1'b0, 0, 2, "R3 write closed bank");
    step(C_PRE, 0, 1'b0, -1, 0, "R13 precharge idle bank");
    step(C_DES, 0, 1'b0, -1, 0, "R2 deselect with strobes low");
    step(C_REF, 0, 1'b0, -1, 0, "R2 unhandled strobe pattern");
    step(C_ACT, 0, 1'b0, -1, 0, "R1 R2 R13 first activate legal");
    idle(T_RC);
    step(C_ACT, 0, 1'b0, 1, 0, "R4 activate open bank");

    // R5 R10 R6 R12: same-bank activate sweep over precharge and reopen points
    for (int p = T_RAS; p <= T_RAS + 2; p++) begin
      for (int k = p + 1; k <= p + 6; k++) begin
        int e;
        do_reset(0);
        step(C_ACT, 0, 1'b0, -1, 0, "R5 setup act");
        idle(p - 1);
        step(C_PRE, 0, 1'b0, -1, 0, "R9 legal precharge");
        idle(k - p - 1);
        if (k < T_RC) e = 2;
        else if (k - p < T_RP) e = 7;
        else if (k < T_RRD) e = 3;
        else e = -1;
        step(C_ACT, 0, 1'b0, e, 0, "R5 R10 R12 same-bank reopen");
      end
    end

    // R6: cross-bank activate spacing
    for (int b = 1; b <= 3; b++) begin
      for (int k = 1; k <= 4; k++) begin
        do_reset(0);
        step(C_ACT, 0, 1'b0, -1, 0, "R6 setup act");
        idle(k - 1);
        step(C_ACT, b, 1'b0, (k < T_RRD) ? 3 : -1, b, "R6 cross-bank act");
      end
    end

    // R7: activate to posted read with every additive latency
    for (int al = 0; al <= 6; al++) begin
      for (int k = 1; k <= 5; k++) begin
        do_reset(al);
        step(C_ACT, 2, 1'b0, -1, 0, "R7 setup act");
        idle(k - 1);
        step(C_RD, 2, 1'b0, (k + al < T_RCD) ? 4 : -1, 2, "R7 posted read");
      end
    end

    // R8: read-to-read spacing across banks
    for (int k = 1; k <= 4; k++) begin
      do_reset(0);
      step(C_ACT, 0, 1'b0, -1, 0, "R8 setup act0");
      idle(1);
      step(C_ACT, 1, 1'b0, -1, 0, "R8 setup act1");
      idle(6);
      step(C_RD, 0, 1'b0, -1, 0, "R8 first read");
      idle(k - 1);
      step(C_RD, 1, 1'b0, (k < T_CCD) ? 5 : -1, 1, "R8 second read");
    end

    // R9: single-bank active time
    for (int k = 1; k <= 7; k++) begin
      do_reset(0);
      step(C_ACT, 3, 1'b0, -1, 0, "R9 setup act");
      idle(k - 1);
      step(C_PRE, 3, 1'b0, (k < T_RAS) ? 6 : -1, 3, "R9 single precharge");
    end

    // R9: precharge-all reports lowest offending bank, then all closed
    for (int d = 4; d <= 10; d++) begin
      int e, eb;
      do_reset(0);
      step(C_ACT, 1, 1'b0, -1, 0, "R9 setup act1");
      idle(2);
      step(C_ACT, 3, 1'b0, -1, 0, "R9 setup act3");
      idle(d - 4);
      if (d < T_RAS) begin e = 6; eb = 1; end
      else if (d - 3 < T_RAS) begin e = 6; eb = 3; end
      else begin e = -1; eb = 0; end
      step(C_PRE, 0, 1'b1, e, eb, "R9 precharge all");
      step(C_RD, 3, 1'b0, 0, 3, "R9 bank closed after precharge all");
    end

    // R11 R10: auto-precharge closes and starts the precharge timer
    for (int k = 1; k <= 5; k++) begin
      do_reset(0);
      step(C_ACT, 1, 1'b0, -1, 0, "R11 setup act");
      idle(7);
      step(C_RD, 1, 1'b1, -1, 0, "R11 auto-precharge read");
      idle(k - 1);
      step(C_ACT, 1, 1'b0, (k < T_RP) ? 7 : -1, 1, "R10 R11 reopen after auto-precharge");
    end
    do_reset(0);
    step(C_ACT, 2, 1'b0, -1, 0, "R11 setup act");
    idle(7);
    step(C_WR, 2, 1'b1, -1, 0, "R11 auto-precharge write");
    idle(3);
    step(C_RD, 2, 1'b0, 0, 2, "R11 access after auto-precharge");

    drive(C_NOP, 0, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule